// File: doc/BRIEF.md
# Programmable CRC32 Word Engine

This block computes a 32-bit CRC over a stream of 32-bit words with a polynomial chosen at run time. When software writes the polynomial, the block spends 256 clocks filling an internal byte lookup table. It raises a table-ready status bit when the fill is finished. Software then seeds the running CRC, loads a word count and sets the enable bit. Words arrive on a valid/ready stream that stands in for a DMA channel. Any data shorter than a word must be zero-padded to 32 bits before it is presented.

Each accepted word is folded into the CRC one byte per clock, least significant byte first. This takes four clocks per word. The CRC uses the reflected (shift-right) form, so the polynomial is written bit-reversed, for example 0xEDB88320. The hardware applies no final inversion. When the last counted word finishes, a sticky done flag is set. In check mode, the final CRC is also compared with a reference register. Each flag can raise the interrupt once it is enabled.

Top module: `crc32_word_engine`

## Requirements
- R1: A write to the polynomial register (address 1) clears status bit 0 (table ready) and starts a table fill. Bit 0 reads 1 only after the 256th clock edge following the write edge.
- R2: A write to the result register (address 2) seeds the CRC. A read of that register returns the current CRC.
- R3: A word w updates the CRC c as follows: c ^= w, then 32 times c = c[0] ? (c>>1)^poly : c>>1. The hardware applies no final inversion.
- R4: `in_ready` is high only when all of these hold: enable is set (control bit 0), the table is ready and not filling, the count is non-zero and no word is in progress. After an acceptance it stays low for 3 clocks, so one word is accepted at most every 4 clocks. A held word is stalled, not dropped.
- R5: The count register (address 3) loads on a write and decrements by one for each accepted word. A read returns the remaining count.
- R6: Status bit 1 (done) is set on the clock edge that finishes the word which brought the count to zero. It stays set until a 1 is written to bit 1 of the status register (address 4). Writing 0 has no effect.
- R7: A write to the interrupt-enable register (address 5) sets enables and never clears them: bit 1 enables done and bit 2 enables mismatch. `irq` is high while any enabled status flag is set.
- R8: In check mode (control bits 2:1 = 1), status bit 2 (mismatch) is set when the final CRC differs from the compare register (address 6). It is not set when they match, and it is never set in calculate mode (0). It is cleared by writing 1 to it.
- R9: After reset, all status bits, the count, the CRC, the enables and the control register read 0, and `in_ready` is low.
- R10: After a second polynomial is loaded and its table fill completes, words are folded with the new polynomial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Engine accepts the word this cycle |
| irq | output | 1 | Interrupt, level |

## Verification
Each result has a fixed arrival time. The table-ready bit appears 256 edges after the polynomial write edge. The CRC and the done or mismatch flags settle three edges after the acceptance edge of the last word, and a register write takes effect on the edge that samples it. The bench keeps a reference model that advances on every rising edge using the inputs it drove. It compares `in_ready` and `irq` against that model a quarter period after each edge. Register reads are sampled in the low half of the clock, and reads that check a result wait until the model shows no word in progress. Table-ready is probed one cycle before and on its due cycle.

// File: rtl/crcw_pkg.sv
package crcw_pkg;
  localparam int CRC_W  = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_POLY   = 3'd1;
  localparam logic [REG_AW-1:0] RA_RESULT = 3'd2;
  localparam logic [REG_AW-1:0] RA_COUNT  = 3'd3;
  localparam logic [REG_AW-1:0] RA_STATUS = 3'd4;
  localparam logic [REG_AW-1:0] RA_IEN    = 3'd5;
  localparam logic [REG_AW-1:0] RA_CMP    = 3'd6;

  localparam int ST_TBL  = 0;
  localparam int ST_DONE = 1;
  localparam int ST_MISS = 2;

  typedef enum logic [1:0] {MODE_CALC = 2'd0, MODE_CHECK = 2'd1} op_mode_e;

  // one table entry: eight reflected shift steps of the index byte
  function automatic logic [CRC_W-1:0] tbl_entry(input logic [7:0] idx,
                                                 input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    c = {{(CRC_W-8){1'b0}}, idx};
    for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    return c;
  endfunction
endpackage

// File: rtl/crcw_table.sv
module crcw_table
  import crcw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CRC_W-1:0] poly_i,
  input  logic [7:0]       idx_i,
  output logic [CRC_W-1:0] val_o,
  output logic [CRC_W-1:0] poly_o,
  output logic             busy_o,
  output logic             ready_o
);
  localparam int ENTRIES = 256;

  logic [CRC_W-1:0] mem [ENTRIES];
  logic [7:0]       idx_q, idx_d;
  logic             busy_q, busy_d, rdy_q, rdy_d;
  logic [CRC_W-1:0] poly_q, poly_d;

  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    rdy_d  = rdy_q;
    poly_d = poly_q;
    if (start_i) begin
      poly_d = poly_i;
      busy_d = 1'b1;
      rdy_d  = 1'b0;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 8'd1;
      if (idx_q == 8'hFF) begin
        busy_d = 1'b0;
        rdy_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      poly_q <= '0;
    end else begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
      rdy_q  <= rdy_d;
      poly_q <= poly_d;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_q && !start_i) mem[idx_q] <= tbl_entry(idx_q, poly_q);
  end

  assign val_o   = mem[idx_i];
  assign poly_o  = poly_q;
  assign busy_o  = busy_q;
  assign ready_o = rdy_q;

  // R1
  tbl_ready_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $past(busy_q));
endmodule

// File: rtl/crcw_engine.sv
module crcw_engine
  import crcw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow_i,
  input  logic             in_valid_i,
  input  logic [CRC_W-1:0] in_data_i,
  output logic             in_ready_o,
  input  logic             seed_we_i,
  input  logic             cnt_we_i,
  input  logic [CRC_W-1:0] wdata_i,
  output logic [7:0]       tbl_idx_o,
  input  logic [CRC_W-1:0] tbl_val_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] crc_nxt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam int BYTES  = CRC_W / 8;
  localparam int BSEL_W = $clog2(BYTES);

  logic              busy_q, busy_d;
  logic [BSEL_W-1:0] bsel_q, bsel_d;
  logic [CRC_W-1:0]  word_q, word_d, crc_q, crc_d, step;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        cur_byte;
  logic              accept;

  assign in_ready_o = allow_i && !busy_q && (cnt_q != '0);
  assign accept     = in_valid_i && in_ready_o;
  assign cur_byte   = busy_q ? word_q[{bsel_q, 3'b000} +: 8] : in_data_i[7:0];
  assign tbl_idx_o  = crc_q[7:0] ^ cur_byte;
  assign step       = (crc_q >> 8) ^ tbl_val_i;

  always_comb begin
    busy_d = busy_q;
    bsel_d = bsel_q;
    word_d = word_q;
    crc_d  = crc_q;
    cnt_d  = cnt_q;
    if (accept) begin
      word_d = in_data_i;
      busy_d = 1'b1;
      bsel_d = BSEL_W'(1);
      crc_d  = step;
      cnt_d  = cnt_q - 1'b1;
    end else if (busy_q) begin
      crc_d  = step;
      bsel_d = bsel_q + 1'b1;
      if (bsel_q == BSEL_W'(BYTES - 1)) busy_d = 1'b0;
    end
    if (seed_we_i) crc_d = wdata_i;
    if (cnt_we_i)  cnt_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bsel_q <= '0;
      word_q <= '0;
      crc_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      bsel_q <= bsel_d;
      word_q <= word_d;
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
    end
  end

  assign crc_o     = crc_q;
  assign crc_nxt_o = step;
  assign cnt_o     = cnt_q;
  assign last_o    = busy_q && (bsel_q == BSEL_W'(BYTES - 1)) && (cnt_q == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cnt_we_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready_o);
endmodule

// File: rtl/crc32_word_engine.sv
module crc32_word_engine
  import crcw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CRC_W-1:0]  reg_wdata,
  output logic [CRC_W-1:0]  reg_rdata,
  input  logic              in_valid,
  input  logic [CRC_W-1:0]  in_data,
  output logic              in_ready,
  output logic              irq
);
  logic             en_q, en_d, done_q, done_d, miss_q, miss_d;
  op_mode_e         mode_q, mode_d;
  logic [1:0]       ien_q, ien_d;
  logic [CRC_W-1:0] cmp_q, cmp_d;

  logic             wr_ctrl, wr_poly, wr_res, wr_cnt, wr_st, wr_ien, wr_cmp;
  logic [7:0]       tbl_idx;
  logic [CRC_W-1:0] tbl_val, tbl_poly, crc, crc_nxt;
  logic             tbl_busy, tbl_ready, last;
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_poly = reg_we && (reg_addr == RA_POLY);
  assign wr_res  = reg_we && (reg_addr == RA_RESULT);
  assign wr_cnt  = reg_we && (reg_addr == RA_COUNT);
  assign wr_st   = reg_we && (reg_addr == RA_STATUS);
  assign wr_ien  = reg_we && (reg_addr == RA_IEN);
  assign wr_cmp  = reg_we && (reg_addr == RA_CMP);

  crcw_table u_table (
    .clk(clk), .rst_n(rst_n), .start_i(wr_poly), .poly_i(reg_wdata),
    .idx_i(tbl_idx), .val_o(tbl_val), .poly_o(tbl_poly),
    .busy_o(tbl_busy), .ready_o(tbl_ready)
  );

  crcw_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .allow_i(en_q && tbl_ready && !tbl_busy),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .seed_we_i(wr_res), .cnt_we_i(wr_cnt), .wdata_i(reg_wdata),
    .tbl_idx_o(tbl_idx), .tbl_val_i(tbl_val), .crc_o(crc),
    .crc_nxt_o(crc_nxt), .cnt_o(cnt), .last_o(last)
  );

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    ien_d  = ien_q;
    cmp_d  = cmp_q;
    done_d = done_q;
    miss_d = miss_q;
    if (wr_ctrl) begin
      en_d   = reg_wdata[0];
      mode_d = op_mode_e'(reg_wdata[2:1]);
    end
    if (wr_ien) ien_d = ien_q | {reg_wdata[ST_MISS], reg_wdata[ST_DONE]};
    if (wr_cmp) cmp_d = reg_wdata;
    if (wr_st && reg_wdata[ST_DONE]) done_d = 1'b0;
    if (wr_st && reg_wdata[ST_MISS]) miss_d = 1'b0;
    if (last) begin
      done_d = 1'b1;
      if (mode_q == MODE_CHECK && crc_nxt != cmp_q) miss_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= MODE_CALC;
      ien_q  <= '0;
      cmp_q  <= '0;
      done_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      ien_q  <= ien_d;
      cmp_q  <= cmp_d;
      done_q <= done_d;
      miss_q <= miss_d;
    end
  end

  assign irq = (ien_q[0] && done_q) || (ien_q[1] && miss_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata = {{(CRC_W-3){1'b0}}, mode_q, en_q};
      RA_POLY:   reg_rdata = tbl_poly;
      RA_RESULT: reg_rdata = crc;
      RA_COUNT:  reg_rdata = CRC_W'(cnt);
      RA_STATUS: reg_rdata = {{(CRC_W-3){1'b0}}, miss_q, done_q, tbl_ready};
      RA_IEN:    reg_rdata = {{(CRC_W-3){1'b0}}, ien_q, 1'b0};
      RA_CMP:    reg_rdata = cmp_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R4
  no_feed_in_build_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_busy |-> !in_ready);
  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_st && reg_wdata[ST_DONE])) |=> done_q);
  // R8
  miss_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_q && mode_q != MODE_CHECK) |=> !miss_q);
endmodule

// File: tb/crc32_word_engine_bench.sv
module crc32_word_engine_bench;
  localparam int CLK_P = 10;
  localparam int WD    = 150000;

  logic        clk, rst_n, reg_we, in_valid;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, in_data;
  logic        in_ready, irq;

  crc32_word_engine u_crc32_word_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model state
  logic [31:0] m_crc, m_poly, m_cmp;
  int m_cnt, m_busy, m_build, m_ien;
  bit m_en, m_lut, m_exp, m_miss, m_pend;
  int m_mode;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] d,
                                          input logic [31:0] p);
    c = c ^ d;
    for (int i = 0; i < 32; i++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    return c;
  endfunction

  function automatic bit m_ready();
    return m_en && m_cnt != 0 && m_lut && m_build == 0 && m_busy == 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_crc = 0; m_poly = 0; m_cmp = 0; m_cnt = 0; m_busy = 0; m_build = 0;
      m_ien = 0; m_en = 0; m_lut = 0; m_exp = 0; m_miss = 0; m_pend = 0; m_mode = 0;
    end else begin
      bit acc;
      acc = in_valid && m_ready();
      if (m_busy > 0) begin
        m_busy--;
        if (m_busy == 0 && m_pend) begin
          m_exp = 1;
          if (m_mode == 1 && m_crc != m_cmp) m_miss = 1;
          m_pend = 0;
        end
      end
      if (acc) begin
        m_crc = ref_crc(m_crc, in_data, m_poly);
        m_cnt--;
        m_busy = 3;
        m_pend = (m_cnt == 0);
      end
      if (m_build > 0) begin
        m_build--;
        if (m_build == 0) m_lut = 1;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin m_en = reg_wdata[0]; m_mode = int'(reg_wdata[2:1]); end
          3'd1: begin m_poly = reg_wdata; m_build = 256; m_lut = 0; end
          3'd2: m_crc = reg_wdata;
          3'd3: m_cnt = int'(reg_wdata[15:0]);
          3'd4: begin
            if (reg_wdata[1]) m_exp = 0;
            if (reg_wdata[2]) m_miss = 0;
          end
          3'd5: m_ien = m_ien | int'(reg_wdata[2:1]);
          3'd6: m_cmp = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, a quarter period after each edge
  always begin
    bit exp_irq;
    @(posedge clk);
    #(CLK_P/4);
    cyc++;
    if (rst_n) begin
      exp_irq = ((m_ien & 1) != 0 && m_exp) || ((m_ien & 2) != 0 && m_miss);
      // R4
      chk(in_ready == m_ready(), "R4 in_ready", 32'(in_ready), 32'(m_ready()));
      // R7
      chk(irq == exp_irq, "R7 irq", 32'(irq), 32'(exp_irq));
    end
    if (cyc > WD) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got %0d exp %0d", cyc, WD);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    while (m_busy != 0) @(negedge clk);
  endtask

  initial begin
    logic [31:0] e;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; in_valid = 0; in_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    rd(3'd4, 0, "R9 status");
    rd(3'd2, 0, "R9 result");
    rd(3'd3, 0, "R9 count");
    rd(3'd0, 0, "R9 ctrl");
    rd(3'd5, 0, "R9 ien");

    // R1 table fill timing, with the block already enabled and armed
    wr(3'd0, 32'h1);
    wr(3'd3, 32'd1);
    wr(3'd1, 32'hEDB88320);
    rd(3'd4, 0, "R1 ready low after write");
    repeat (255) @(negedge clk);
    rd(3'd4, 0, "R1 ready low at 255");
    @(negedge clk);
    rd(3'd4, 1, "R1 ready at 256");

    // R2 seed
    wr(3'd2, 32'hFFFFFFFF);
    rd(3'd2, 32'hFFFFFFFF, "R2 seed readback");

    // R3 R5 R6 three words
    wr(3'd3, 32'd3);
    rd(3'd3, 3, "R5 count load");
    wr(3'd5, 32'h2);
    e = 32'hFFFFFFFF;
    send(32'h04030201); e = ref_crc(e, 32'h04030201, 32'hEDB88320);
    rd(3'd3, 2, "R5 count after one word");
    send(32'hDEADBEEF); e = ref_crc(e, 32'hDEADBEEF, 32'hEDB88320);
    send(32'h00000000); e = ref_crc(e, 32'h00000000, 32'hEDB88320);
    wait_idle();
    rd(3'd2, e, "R3 crc three words");
    rd(3'd3, 0, "R5 count zero");
    rd(3'd4, 3, "R6 done set");

    // R4 stall with count zero, word must survive
    in_valid = 1; in_data = 32'hA5A5_0F0F;
    repeat (6) @(negedge clk);
    rd(3'd3, 0, "R4 stalled count");
    rd(3'd2, e, "R4 crc unchanged while stalled");
    wr(3'd3, 32'd1);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    e = ref_crc(e, 32'hA5A5_0F0F, 32'hEDB88320);
    wait_idle();
    rd(3'd2, e, "R4 stalled word folded");

    // R6 write-1-to-clear
    wr(3'd4, 32'h0);
    rd(3'd4, 3, "R6 zero write ignored");
    wr(3'd4, 32'h2);
    rd(3'd4, 1, "R6 cleared");

    // R8 check mode, matching then mismatching
    wr(3'd0, 32'h3);
    wr(3'd5, 32'h4);
    rd(3'd5, 32'h6, "R7 enables accumulate");
    wr(3'd2, 32'h12345678);
    e = ref_crc(ref_crc(32'h12345678, 32'h11111111, 32'hEDB88320), 32'h80000001, 32'hEDB88320);
    wr(3'd6, e);
    wr(3'd3, 32'd2);
    send(32'h11111111);
    send(32'h80000001);
    wait_idle();
    rd(3'd2, e, "R3 crc check mode");
    rd(3'd4, 3, "R8 match no mismatch");
    wr(3'd4, 32'h2);
    wr(3'd2, 32'h12345678);
    wr(3'd6, e ^ 32'h1);
    wr(3'd3, 32'd2);
    send(32'h11111111);
    send(32'h80000001);
    wait_idle();
    rd(3'd4, 7, "R8 mismatch set");
    wr(3'd4, 32'h6);
    rd(3'd4, 1, "R8 mismatch cleared");

    // R4 disabled: held word not taken
    wr(3'd0, 32'h0);
    wr(3'd3, 32'd2);
    in_valid = 1; in_data = 32'h5;
    repeat (8) @(negedge clk);
    rd(3'd3, 2, "R4 disabled count held");
    in_valid = 0;

    // R10 new polynomial
    wr(3'd1, 32'h82F63B78);
    rd(3'd4, 0, "R1 ready cleared on new poly");
    while (!m_lut) @(negedge clk);
    rd(3'd1, 32'h82F63B78, "R10 poly readback");
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'd1);
    send(32'hCAFEF00D);
    wait_idle();
    rd(3'd2, ref_crc(32'h0, 32'hCAFEF00D, 32'h82F63B78), "R10 crc new poly");

    repeat (4) @(negedge clk);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule